// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps wall-clock time and a calendar as packed BCD bytes. Seven bytes hold seconds, minutes, hours, day of week, date, month and year, and an eighth byte holds a control word. A divider elsewhere supplies a one-cycle enable once per second. On each enable the seconds field counts up, and a rollover carries through minutes, hours, day of week and date, then month and year. The date rolls over at the length of the current month, which accounts for leap years.

A bus front end reads and writes the eight bytes through a simple byte port: a 3-bit address, a write strobe, write data, and combinational read data. The top bit of the seconds byte is a halt flag that freezes timekeeping while it is set. The control byte drives four output fields: a static output level, a frequency-test enable, a calibration direction and a calibration magnitude. Those fields go to the divider and pin logic next to this block.

Top module: `rtcc_regfile`

## Requirements
- R1: After reset, addresses 0 to 7 read 00, 00, 00, 01, 01, 01, 00, 00, and all control outputs are 0.
- R2: Bits with no meaning read as zero and ignore writes. The readback masks are FF for address 0, 7F for minutes, 3F for hours, 07 for day of week, 3F for date, 1F for month, FF for year and FF for control.
- R3: Each enable adds one to seconds in packed BCD, with tens in bits 6:4 and units in bits 3:0 (for example 09 becomes 10). Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Hours roll from 23 to 00 and carry into the day of week and the date.
- R4: While bit 7 of address 0 is 1, enables change no time field. Once the bit is written back to 0, counting resumes.
- R5: At midnight the day of week advances by one, and it wraps from 07 to 01.
- R6: At midnight, a date at or past the last day of its month becomes 01 and carries into the month. Months 04, 06, 09 and 11 have 30 days, and the other months have 31, except month 02. Month 02 has 29 days when the year is a multiple of 4 (00 included) and 28 days otherwise.
- R7: A carry into the month rolls 12 to 01 and carries into the year. The year rolls from 99 to 00.
- R8: A write to any of addresses 0 to 6 in the same cycle as an enable stores the written value, and that enable is discarded entirely. A write to address 7 does not discard the enable.
- R9: The control byte at address 7 drives four outputs. Bit 7 drives `ctl_level`, bit 6 drives `ctl_freq_test`, bit 5 drives `ctl_cal_pos`, and bits 4:0 drive `ctl_cal_mag`. Only a write to address 7 changes the control byte.
- R10: With no enable and no write, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | Once-per-second advance enable |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ctl_level | output | 1 | Static output level from the control byte |
| ctl_freq_test | output | 1 | Frequency-test enable |
| ctl_cal_pos | output | 1 | Calibration direction, 1 = speed up |
| ctl_cal_mag | output | 5 | Calibration magnitude |

## Verification
The assertions check several behaviours on every cycle. The time fields stay frozen while halted and stay unchanged when the block is idle. Seconds wrap from 59 to 00 on an enable. A write overrides the minutes field. The control outputs follow only writes to address 7.

Some behaviours can only be shown by the bench's scenarios. These are the month-length table, the leap-year rule for years 00, 23 and 24, and the full carry chain from 31 Dec 99 23:59:59. The discarded enable during a write also needs those scenarios, and so does agreement with a reference model over a long random run of writes and enables.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int NUM_TIME = 7;

    localparam logic [ADDR_W-1:0] ADR_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_WDAY = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_DATE = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_MON  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_YEAR = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd7;

    // Packed BCD increment on two digits.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [3:0] tens;
        tens = v[7:4] + 4'd1;
        if (v[3:0] >= 4'd9) return {tens, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Meaningful bits of each counting field (seconds halt flag kept apart).
    function automatic logic [7:0] field_mask(input logic [ADDR_W-1:0] a);
        unique case (a)
            ADR_SEC:  return 8'h7F;
            ADR_MIN:  return 8'h7F;
            ADR_HOUR: return 8'h3F;
            ADR_WDAY: return 8'h07;
            ADR_DATE: return 8'h3F;
            ADR_MON:  return 8'h1F;
            default:  return 8'hFF;
        endcase
    endfunction

    // Reset value and wrap floor share one table: fields counted from one start at 01.
    function automatic logic [7:0] field_base(input logic [ADDR_W-1:0] a);
        unique case (a)
            ADR_WDAY, ADR_DATE, ADR_MON: return 8'h01;
            default:                     return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/rtcc_month_len.sv
module rtcc_month_len
    import rtcc_pkg::*;
(
    input  logic [7:0] mon_bcd,
    input  logic [4:0] yr_low,
    output logic [7:0] last_day
);
    logic leap;

    // tens digit parity is bit 4; a BCD year is a multiple of 4 when
    // (tens even, units 0/4/8) or (tens odd, units 2/6)
    always_comb begin
        if (yr_low[4]) leap = (yr_low[3:0] == 4'd2) || (yr_low[3:0] == 4'd6);
        else           leap = (yr_low[3:0] == 4'd0) || (yr_low[3:0] == 4'd4) ||
                              (yr_low[3:0] == 4'd8);
    end

    always_comb begin
        unique case (mon_bcd)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtcc_field.sv
module rtcc_field
    import rtcc_pkg::*;
#(
    parameter logic [7:0] BASE = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       step,
    input  logic [7:0] top_val,
    output logic [7:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= BASE;
        else if (load)   q <= load_val;
        else if (step)   q <= (q >= top_val) ? BASE : bcd_inc(q);
    end
endmodule

// File: rtl/rtcc_regfile.sv
module rtcc_regfile
    import rtcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ctl_level,
    output logic              ctl_freq_test,
    output logic              ctl_cal_pos,
    output logic [4:0]        ctl_cal_mag
);
    logic [7:0] fld_q   [NUM_TIME];
    logic [7:0] fld_top [NUM_TIME];
    logic       fld_step[NUM_TIME];
    logic [7:0] date_last;
    logic       stop_q;
    logic [7:0] ctrl_q;
    logic       time_wr;
    logic       adv;
    logic       c_sec, c_min, c_hour, c_date, c_mon;
    logic [8*NUM_TIME-1:0] time_vec;

    rtcc_month_len u_mlen (
        .mon_bcd  (fld_q[ADR_MON]),
        .yr_low   (fld_q[ADR_YEAR][4:0]),
        .last_day (date_last)
    );

    // A host write to a time byte discards a coincident tick (R8).
    assign time_wr = bus_wr && (bus_addr != ADR_CTRL);
    assign adv     = tick_1hz && !stop_q && !time_wr;

    always_comb begin
        fld_top[ADR_SEC]  = 8'h59;
        fld_top[ADR_MIN]  = 8'h59;
        fld_top[ADR_HOUR] = 8'h23;
        fld_top[ADR_WDAY] = 8'h07;
        fld_top[ADR_DATE] = date_last;
        fld_top[ADR_MON]  = 8'h12;
        fld_top[ADR_YEAR] = 8'h99;
    end

    // Carry chain
    always_comb begin
        c_sec  = adv    && (fld_q[ADR_SEC]  >= fld_top[ADR_SEC]);
        c_min  = c_sec  && (fld_q[ADR_MIN]  >= fld_top[ADR_MIN]);
        c_hour = c_min  && (fld_q[ADR_HOUR] >= fld_top[ADR_HOUR]);
        c_date = c_hour && (fld_q[ADR_DATE] >= fld_top[ADR_DATE]);
        c_mon  = c_date && (fld_q[ADR_MON]  >= fld_top[ADR_MON]);
        fld_step[ADR_SEC]  = adv;
        fld_step[ADR_MIN]  = c_sec;
        fld_step[ADR_HOUR] = c_min;
        fld_step[ADR_WDAY] = c_hour;
        fld_step[ADR_DATE] = c_hour;
        fld_step[ADR_MON]  = c_date;
        fld_step[ADR_YEAR] = c_mon;
    end

    for (genvar i = 0; i < NUM_TIME; i++) begin : g_fld
        localparam logic [ADDR_W-1:0] FA = ADDR_W'(i);
        rtcc_field #(.BASE(field_base(FA))) u_fld (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (bus_wr && (bus_addr == FA)),
            .load_val (bus_wdata & field_mask(FA)),
            .step     (fld_step[i]),
            .top_val  (fld_top[i]),
            .q        (fld_q[i])
        );
        assign time_vec[8*i +: 8] = fld_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            ctrl_q <= 8'h00;
        end else if (bus_wr) begin
            if (bus_addr == ADR_SEC)  stop_q <= bus_wdata[7];
            if (bus_addr == ADR_CTRL) ctrl_q <= bus_wdata;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_SEC:  bus_rdata = {stop_q, fld_q[ADR_SEC][6:0]};
            ADR_CTRL: bus_rdata = ctrl_q;
            default:  bus_rdata = fld_q[bus_addr];
        endcase
    end

    assign ctl_level     = ctrl_q[7];
    assign ctl_freq_test = ctrl_q[6];
    assign ctl_cal_pos   = ctrl_q[5];
    assign ctl_cal_mag   = ctrl_q[4:0];
endmodule

// File: rtl/rtcc_checker.sv
module rtcc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_1hz,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [55:0] time_vec,
    input logic        stop_q,
    input logic        ctl_level,
    input logic        ctl_freq_test,
    input logic        ctl_cal_pos,
    input logic [4:0]  ctl_cal_mag
);
    a_r4_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !bus_wr) |=> $stable(time_vec));

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !bus_wr) |=> ($stable(time_vec) && $stable(stop_q)));

    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !stop_q && !bus_wr && time_vec[7:0] == 8'h59) |=> (time_vec[7:0] == 8'h00));

    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> (time_vec[15:8] == {1'b0, $past(bus_wdata[6:0])}));

    a_r9_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd7) |=>
        ({ctl_level, ctl_freq_test, ctl_cal_pos, ctl_cal_mag} == $past(bus_wdata)));

    a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 3'd7) |=>
        $stable({ctl_level, ctl_freq_test, ctl_cal_pos, ctl_cal_mag}));
endmodule

bind rtcc_regfile rtcc_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_1hz      (tick_1hz),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .time_vec      (time_vec),
    .stop_q        (stop_q),
    .ctl_level     (ctl_level),
    .ctl_freq_test (ctl_freq_test),
    .ctl_cal_pos   (ctl_cal_pos),
    .ctl_cal_mag   (ctl_cal_mag)
);

// File: tb/tb_rtcc_regfile.sv
module tb_rtcc_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ctl_level, ctl_freq_test, ctl_cal_pos;
    logic [4:0] ctl_cal_mag;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] m [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtcc_regfile dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctl_level(ctl_level), .ctl_freq_test(ctl_freq_test),
        .ctl_cal_pos(ctl_cal_pos), .ctl_cal_mag(ctl_cal_mag)
    );

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] rmask(input int a);
        case (a)
            1: return 8'h7F;
            2: return 8'h3F;
            3: return 8'h07;
            4: return 8'h3F;
            5: return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic int mdays(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // Reference model: one second of advance.
    task automatic model_tick();
        int s, mi, h, wd, d, mo, y;
        s = b2i(m[0] & 8'h7F); mi = b2i(m[1]); h = b2i(m[2]); wd = b2i(m[3]);
        d = b2i(m[4]); mo = b2i(m[5]); y = b2i(m[6]);
        if (s >= 59) begin
            s = 0;
            if (mi >= 59) begin
                mi = 0;
                if (h >= 23) begin
                    h = 0;
                    wd = (wd >= 7) ? 1 : wd + 1;
                    if (d >= mdays(mo, y)) begin
                        d = 1;
                        if (mo >= 12) begin
                            mo = 1;
                            y = (y >= 99) ? 0 : y + 1;
                        end else mo++;
                    end else d++;
                end else h++;
            end else mi++;
        end else s++;
        m[0] = {m[0][7], i2b(s)[6:0]}; m[1] = i2b(mi); m[2] = i2b(h); m[3] = i2b(wd);
        m[4] = i2b(d); m[5] = i2b(mo); m[6] = i2b(y);
    endtask

    task automatic do_cyc(input logic w, input logic [2:0] a, input logic [7:0] d, input logic t);
        logic halted;
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick_1hz = t;
        @(posedge clk);
        halted = m[0][7];
        if (w) m[a] = d & rmask(int'(a));
        if (t && !halted && !(w && a != 3'd7)) model_tick();
        #1;
        bus_wr = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        bus_wr = 1'b0; tick_1hz = 1'b0; bus_addr = a;
        #1;
        n_tests++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0d: actual %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_ctl(input logic [7:0] exp, input string tag);
        n_tests++;
        if ({ctl_level, ctl_freq_test, ctl_cal_pos, ctl_cal_mag} !== exp) begin
            n_fail++;
            $display("FAIL %s ctl: actual %h expected %h", tag,
                     {ctl_level, ctl_freq_test, ctl_cal_pos, ctl_cal_mag}, exp);
        end
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, wd, d, mo, y);
        do_cyc(1'b1, 3'd0, s, 1'b0);  do_cyc(1'b1, 3'd1, mi, 1'b0);
        do_cyc(1'b1, 3'd2, h, 1'b0);  do_cyc(1'b1, 3'd3, wd, 1'b0);
        do_cyc(1'b1, 3'd4, d, 1'b0);  do_cyc(1'b1, 3'd5, mo, 1'b0);
        do_cyc(1'b1, 3'd6, y, 1'b0);
    endtask

    function automatic logic [7:0] rand_val(input int a);
        case (a)
            0: return {($urandom % 8 == 0) ? 1'b1 : 1'b0, i2b($urandom % 60)[6:0]};
            1: return i2b($urandom % 60);
            2: return i2b($urandom % 24);
            3: return i2b(1 + $urandom % 7);
            4: return i2b(1 + $urandom % 31);
            5: return i2b(1 + $urandom % 12);
            6: return i2b($urandom % 100);
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd20240229);
        m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
        m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00; m[7] = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 8; a++) chk(3'(a), m[a], "R1 reset");
        chk_ctl(8'h00, "R1 reset");

        // R2 masked readback
        for (int a = 0; a < 8; a++) begin
            do_cyc(1'b1, 3'(a), 8'hFF, 1'b0);
            chk(3'(a), rmask(a), "R2 mask");
        end

        // R9 control fields
        do_cyc(1'b1, 3'd7, 8'hA5, 1'b0);
        chk_ctl(8'hA5, "R9 ctrl fields");
        n_tests++;
        if (!(ctl_level == 1'b1 && ctl_freq_test == 1'b0 && ctl_cal_pos == 1'b1 && ctl_cal_mag == 5'd5)) begin
            n_fail++;
            $display("FAIL R9 split: actual %b%b%b%h expected 1015", ctl_level, ctl_freq_test, ctl_cal_pos, ctl_cal_mag);
        end

        // R3/R5/R7 full chain from 31 Dec 99 23:59:59, weekday 07
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
        chk(3'd0, 8'h00, "R3 sec wrap"); chk(3'd1, 8'h00, "R3 min wrap");
        chk(3'd2, 8'h00, "R3 hour wrap"); chk(3'd3, 8'h01, "R5 wday wrap");
        chk(3'd4, 8'h01, "R6 date wrap"); chk(3'd5, 8'h01, "R7 month wrap");
        chk(3'd6, 8'h00, "R7 year wrap");
        chk(3'd7, 8'hA5, "R9 ctrl untouched by tick");

        // R6 month lengths and leap years
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
        chk(3'd4, 8'h01, "R6 feb28 yr23"); chk(3'd5, 8'h03, "R6 feb28 yr23 month");
        chk(3'd3, 8'h04, "R5 wday step");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
        chk(3'd4, 8'h29, "R6 feb28 yr24");
        do_cyc(1'b1, 3'd0, 8'h59, 1'b0); do_cyc(1'b1, 3'd1, 8'h59, 1'b0);
        do_cyc(1'b1, 3'd2, 8'h23, 1'b0);
        do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
        chk(3'd4, 8'h01, "R6 feb29 yr24"); chk(3'd5, 8'h03, "R6 feb29 yr24 month");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00);
        do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
        chk(3'd4, 8'h29, "R6 feb28 yr00");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h10);
        do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
        chk(3'd4, 8'h01, "R6 apr30"); chk(3'd5, 8'h05, "R6 apr30 month");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h05, 8'h10);
        do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
        chk(3'd4, 8'h31, "R6 may30");

        // R3 BCD units carry
        set_time(8'h09, 8'h41, 8'h12, 8'h02, 8'h15, 8'h06, 8'h10);
        do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
        chk(3'd0, 8'h10, "R3 bcd carry"); chk(3'd1, 8'h41, "R3 no min carry");

        // R4 halt
        do_cyc(1'b1, 3'd0, 8'h95, 1'b0);
        for (int k = 0; k < 3; k++) do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
        chk(3'd0, 8'h95, "R4 halted");
        do_cyc(1'b1, 3'd0, 8'h15, 1'b0);
        do_cyc(1'b0, 3'd0, 8'h00, 1'b1);
        chk(3'd0, 8'h16, "R4 resumed");

        // R8 write priority over tick
        do_cyc(1'b1, 3'd0, 8'h20, 1'b0);
        do_cyc(1'b1, 3'd1, 8'h33, 1'b1);
        chk(3'd0, 8'h20, "R8 tick dropped"); chk(3'd1, 8'h33, "R8 write kept");
        do_cyc(1'b1, 3'd7, 8'h4C, 1'b1);
        chk(3'd0, 8'h21, "R8 ctrl write keeps tick"); chk_ctl(8'h4C, "R9 ctrl rewrite");

        // R10 idle
        for (int k = 0; k < 4; k++) do_cyc(1'b0, 3'd0, 8'h00, 1'b0);
        chk(3'd0, 8'h21, "R10 idle sec"); chk(3'd1, 8'h33, "R10 idle min");

        // Random mix against the model
        for (int k = 0; k < N_RANDOM; k++) begin
            logic w, t;
            logic [2:0] a;
            w = ($urandom % 10 == 0);
            t = ($urandom % 2 == 0);
            a = 3'($urandom % 8);
            do_cyc(w, a, rand_val(int'(a)), t);
            a = 3'($urandom % 8);
            chk(a, m[a], "R3 random vs model");
        end
        chk_ctl(m[7], "R9 random ctrl");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule